// File: doc/BRIEF.md
# Paged Address Translation Map

This block turns the addresses that a network controller chip puts out into addresses in a board's local memory. The chip drives a 24-bit address, of which the top four bits are dropped. The remaining 20 bits split into a 10-bit slot number and a 10-bit offset within a 1024-byte page. The slot number selects one 16-bit entry in a 1024-slot page table. The entry supplies a physical frame number, a flag that swaps the two byte lanes of 16-bit data moving through that page, and a flag that places the page on an auxiliary bus rather than in onboard memory.

The host reaches board memory through the same table, using a 20-bit address. It also programs and reads the table one 16-bit entry at a time. Translation is combinational on both sides. An entry write lands on the next clock edge. The table has no reset value, so software must program every slot before the chip is allowed to run. Because the top chip address bits are discarded, the last slot covers the controller's fixed start-up pointer near the top of its space. Pointing that slot at frame 0 makes the first page of memory visible at two chip addresses.

Top module: `pgxlat_map`

## Requirements
- R1: The chip-side slot number is chip address bits 19..10. Bits 23..20 have no effect, so two chip addresses that differ only in those bits translate identically.
- R2: Address bits 9..0 pass through unchanged as physical address bits 9..0, on both the chip side and the host side.
- R3: Physical address bits 21..10 equal entry bits 11..0 of the selected slot.
- R4: When entry bit 15 is 1, the data output is the data input with its two bytes exchanged (input bits 7..0 appear on output bits 15..8, and the reverse), and the swap output is 1. When bit 15 is 0, data passes unchanged and the swap output is 0.
- R5: The aux-bus output equals entry bit 13: 1 selects the auxiliary bus, 0 selects onboard memory. Entry bits 14 and 12 affect no translated output.
- R6: The host side translates a 20-bit address through the same table, using bits 19..10 as the slot number. Its outputs equal the chip side's outputs for the same low 20 address bits and the same data.
- R7: An entry write with map_we=1 at a clock edge changes translations from that edge on. A translation in the same cycle as the write still uses the old entry. Without a write, translations of a held address do not change.
- R8: A table read with map_rd=1 returns the full 16-bit entry on map_rdata one clock later, including bits 14 and 12. map_rdata is 0 after reset and holds its value while map_rd is 0.
- R9: Chip address 0xFFFFF4 selects slot 1023 with offset 0x3F4. With slots 1023 and 0 both mapped to frame 0, it gives the same physical address (0x0003F4) as chip address 0x0003F4.
- R10: While a side's request input is 0, that side's physical address, swap, aux and data outputs are all 0.
- R11: A table read with map_we=0 leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (readback register only) |
| chip_req | input | 1 | Chip-side access valid |
| chip_addr | input | 24 | Chip-side address |
| chip_din | input | 16 | 16-bit data entering the chip-side lane path |
| chip_phys | output | 22 | Chip-side physical address {frame, offset} |
| chip_swap | output | 1 | Chip-side byte-lane swap in effect |
| chip_aux | output | 1 | Chip-side page is on the auxiliary bus |
| chip_dout | output | 16 | Chip-side data after lane handling |
| host_req | input | 1 | Host-side access valid |
| host_addr | input | 20 | Host-side address |
| host_din | input | 16 | 16-bit data entering the host-side lane path |
| host_phys | output | 22 | Host-side physical address {frame, offset} |
| host_swap | output | 1 | Host-side byte-lane swap in effect |
| host_aux | output | 1 | Host-side page is on the auxiliary bus |
| host_dout | output | 16 | Host-side data after lane handling |
| map_we | input | 1 | Write map_wdata to slot map_idx |
| map_rd | input | 1 | Read slot map_idx into map_rdata |
| map_idx | input | 10 | Table slot for write or read |
| map_wdata | input | 16 | Entry value to write |
| map_rdata | output | 16 | Registered entry readback |

## Verification
The bench programs all 1024 slots and drives chip addresses with random values in the discarded top nibble. A design that decoded the wrong slot bits, or let the top nibble leak into the slot number, would give the wrong frame. It also checks the start-up pointer alias against the same page reached through slot 0. A design that did not wrap the last slot would not match.

The bench puts a write and a translation of the same slot in one cycle. A design that bypassed the write data would show the new frame one cycle early. Entries with bits 14 and 12 set must read back whole but must not disturb the swap or aux outputs. A design that decoded the wrong entry bit would flip those flags or scramble the byte lanes.

Idle requests must drive every output to 0, so a design that left them ungated would show a stale frame.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

   // Entry bit positions that the lookup logic decodes.
   localparam int ENT_SWAP_BIT = 15;
   localparam int ENT_AUX_BIT  = 13;

   // Bus placement encoded by the aux flag.
   typedef enum logic {
      BUS_ONBOARD = 1'b0,
      BUS_AUX     = 1'b1
   } bus_sel_e;

   localparam int LANE_W = 8;

endpackage

// File: rtl/pgx_map_store.sv
module pgx_map_store #(
   parameter int IDX_W  = 10,
   parameter int ENT_W  = 16,
   parameter bit RD_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [ENT_W-1:0] wr_data,
   input  logic [IDX_W-1:0] a_idx,
   output logic [ENT_W-1:0] a_ent,
   input  logic [IDX_W-1:0] b_idx,
   output logic [ENT_W-1:0] b_ent,
   input  logic             rb_en,
   input  logic [IDX_W-1:0] rb_idx,
   output logic [ENT_W-1:0] rb_data
);

   localparam int SLOTS = 1 << IDX_W;

   // Table contents carry no reset: software programs every slot.
   logic [ENT_W-1:0] tbl [SLOTS];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tbl[wr_idx] <= wr_data;
      end
   end

   // Two independent lookup ports, read before any write in the cycle.
   assign a_ent = tbl[a_idx];
   assign b_ent = tbl[b_idx];

   generate
      if (RD_REG) begin : g_rb_reg
         logic [ENT_W-1:0] rb_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rb_q <= '0;
            end else if (rb_en) begin
               rb_q <= tbl[rb_idx];
            end
         end

         assign rb_data = rb_q;

         AST_RB_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
            (rb_en && !wr_en && $past(wr_en) && ($past(wr_idx) == rb_idx))
            |=> (rb_data == $past(wr_data, 2)))
            else $error("readback missed the preceding write"); // R8

         AST_RB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !rb_en |=> $stable(rb_data))
            else $error("readback changed without a read"); // R8
      end else begin : g_rb_comb
         assign rb_data = rb_en ? tbl[rb_idx] : '0;
      end
   endgenerate

endmodule

// File: rtl/pgx_lookup.sv
module pgx_lookup #(
   parameter int IN_AW     = 24,
   parameter int PAGE_BITS = 10,
   parameter int IDX_W     = 10,
   parameter int FRAME_W   = 12,
   parameter int ENT_W     = 16,
   parameter int DATA_W    = 16,
   parameter bit SWAP_EN   = 1'b1
) (
   input  logic                         req,
   input  logic [IN_AW-1:0]             addr,
   output logic [IDX_W-1:0]             idx,
   input  logic [ENT_W-1:0]             ent,
   input  logic [DATA_W-1:0]            din,
   output logic [FRAME_W+PAGE_BITS-1:0] phys,
   output logic                         swap,
   output logic                         aux,
   output logic [DATA_W-1:0]            dout
);

   localparam int EFF_AW = PAGE_BITS + IDX_W;
   localparam int NLANE  = DATA_W / pgx_pkg::LANE_W;
   localparam int LW     = pgx_pkg::LANE_W;

   // Slot select from the effective address; higher bits are dropped.
   assign idx = addr[PAGE_BITS +: IDX_W];

   generate
      if (IN_AW > EFF_AW) begin : g_drop_hi
         logic unused_hi;
         assign unused_hi = ^addr[IN_AW-1:EFF_AW];
      end
   endgenerate

   // Entry bits outside frame/swap/aux are stored but not decoded.
   logic unused_ent;
   assign unused_ent = ^ent;

   logic [FRAME_W-1:0] frame;
   logic               swap_flag;
   pgx_pkg::bus_sel_e  bus_sel;

   assign frame     = ent[FRAME_W-1:0];
   assign swap_flag = ent[pgx_pkg::ENT_SWAP_BIT];
   assign bus_sel   = pgx_pkg::bus_sel_e'(ent[pgx_pkg::ENT_AUX_BIT]);

   // Lane-reversed copy of the data.
   logic [DATA_W-1:0] lanes_rev;

   generate
      for (genvar k = 0; k < NLANE; k++) begin : g_lane
         assign lanes_rev[k*LW +: LW] = din[(NLANE-1-k)*LW +: LW];
      end
   endgenerate

   logic [DATA_W-1:0] data_sel;

   generate
      if (SWAP_EN) begin : g_swap
         assign data_sel = swap_flag ? lanes_rev : din;
      end else begin : g_noswap
         logic unused_rev;
         assign unused_rev = ^lanes_rev;
         assign data_sel   = din;
      end
   endgenerate

   // Outputs are quiet while no access is requested.
   always_comb begin
      if (req) begin
         phys = {frame, addr[PAGE_BITS-1:0]};
         swap = swap_flag;
         aux  = (bus_sel == pgx_pkg::BUS_AUX);
         dout = data_sel;
      end else begin
         phys = '0;
         swap = 1'b0;
         aux  = 1'b0;
         dout = '0;
      end
   end

endmodule

// File: rtl/pgxlat_map.sv
module pgxlat_map #(
   parameter int CHIP_AW   = 24,
   parameter int PAGE_BITS = 10,
   parameter int IDX_W     = 10,
   parameter int FRAME_W   = 12,
   parameter int ENT_W     = 16,
   parameter int DATA_W    = 16,
   parameter bit SWAP_EN   = 1'b1,
   parameter bit RD_REG    = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         chip_req,
   input  logic [CHIP_AW-1:0]           chip_addr,
   input  logic [DATA_W-1:0]            chip_din,
   output logic [FRAME_W+PAGE_BITS-1:0] chip_phys,
   output logic                         chip_swap,
   output logic                         chip_aux,
   output logic [DATA_W-1:0]            chip_dout,
   input  logic                         host_req,
   input  logic [PAGE_BITS+IDX_W-1:0]   host_addr,
   input  logic [DATA_W-1:0]            host_din,
   output logic [FRAME_W+PAGE_BITS-1:0] host_phys,
   output logic                         host_swap,
   output logic                         host_aux,
   output logic [DATA_W-1:0]            host_dout,
   input  logic                         map_we,
   input  logic                         map_rd,
   input  logic [IDX_W-1:0]             map_idx,
   input  logic [ENT_W-1:0]             map_wdata,
   output logic [ENT_W-1:0]             map_rdata
);

   localparam int EFF_AW = PAGE_BITS + IDX_W;
   localparam int PHYS_W = FRAME_W + PAGE_BITS;

   // Elaboration-time parameter checks.
   generate
      if (CHIP_AW < EFF_AW) begin : g_bad_aw
         $error("chip address narrower than page offset plus slot bits");
      end
      if (ENT_W <= pgx_pkg::ENT_SWAP_BIT) begin : g_bad_ent
         $error("entry too narrow for the swap flag");
      end
      if (FRAME_W > pgx_pkg::ENT_AUX_BIT) begin : g_bad_frame
         $error("frame field overlaps the aux flag");
      end
      if ((DATA_W % pgx_pkg::LANE_W) != 0) begin : g_bad_data
         $error("data width must be a whole number of byte lanes");
      end
   endgenerate

   logic [IDX_W-1:0] chip_idx, host_idx;
   logic [ENT_W-1:0] chip_ent, host_ent;

   pgx_map_store #(
      .IDX_W  (IDX_W),
      .ENT_W  (ENT_W),
      .RD_REG (RD_REG)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (map_we),
      .wr_idx  (map_idx),
      .wr_data (map_wdata),
      .a_idx   (chip_idx),
      .a_ent   (chip_ent),
      .b_idx   (host_idx),
      .b_ent   (host_ent),
      .rb_en   (map_rd),
      .rb_idx  (map_idx),
      .rb_data (map_rdata)
   );

   pgx_lookup #(
      .IN_AW     (CHIP_AW),
      .PAGE_BITS (PAGE_BITS),
      .IDX_W     (IDX_W),
      .FRAME_W   (FRAME_W),
      .ENT_W     (ENT_W),
      .DATA_W    (DATA_W),
      .SWAP_EN   (SWAP_EN)
   ) u_chip_lu (
      .req  (chip_req),
      .addr (chip_addr),
      .idx  (chip_idx),
      .ent  (chip_ent),
      .din  (chip_din),
      .phys (chip_phys),
      .swap (chip_swap),
      .aux  (chip_aux),
      .dout (chip_dout)
   );

   pgx_lookup #(
      .IN_AW     (EFF_AW),
      .PAGE_BITS (PAGE_BITS),
      .IDX_W     (IDX_W),
      .FRAME_W   (FRAME_W),
      .ENT_W     (ENT_W),
      .DATA_W    (DATA_W),
      .SWAP_EN   (SWAP_EN)
   ) u_host_lu (
      .req  (host_req),
      .addr (host_addr),
      .idx  (host_idx),
      .ent  (host_ent),
      .din  (host_din),
      .phys (host_phys),
      .swap (host_swap),
      .aux  (host_aux),
      .dout (host_dout)
   );

   // Cross-port properties.
   AST_SHARED_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      (chip_req && host_req && (chip_addr[EFF_AW-1:0] == host_addr) && (chip_din == host_din))
      |-> ((chip_phys == host_phys) && (chip_swap == host_swap)
           && (chip_aux == host_aux) && (chip_dout == host_dout)))
      else $error("chip and host views disagree"); // R6

   AST_HELD_XLAT: assert property (@(posedge clk) disable iff (!rst_n)
      (chip_req && $past(chip_req) && $stable(chip_addr) && !$past(map_we))
      |-> ($stable(chip_phys) && $stable(chip_swap) && $stable(chip_aux)))
      else $error("translation moved without a table write"); // R7

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_req |-> ((chip_phys == '0) && !chip_swap && !chip_aux && (chip_dout == '0)))
      else $error("idle chip side drives a value"); // R10

   AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      host_req |-> (host_phys[PAGE_BITS-1:0] == host_addr[PAGE_BITS-1:0]))
      else $error("page offset altered"); // R2

   generate
      if (SWAP_EN && (DATA_W == 16)) begin : g_swap_chk
         AST_LANE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
            (chip_req && chip_swap) |-> (chip_dout == {chip_din[7:0], chip_din[15:8]}))
            else $error("byte lanes not exchanged"); // R4
      end
   endgenerate

   logic unused_phys_w;
   assign unused_phys_w = (PHYS_W > 0);

endmodule

// File: tb/pgxlat_map_bench.sv
module pgxlat_map_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chip_req = 1'b0;
   logic [23:0] chip_addr = '0;
   logic [15:0] chip_din = '0;
   logic [21:0] chip_phys;
   logic        chip_swap, chip_aux;
   logic [15:0] chip_dout;
   logic        host_req = 1'b0;
   logic [19:0] host_addr = '0;
   logic [15:0] host_din = '0;
   logic [21:0] host_phys;
   logic        host_swap, host_aux;
   logic [15:0] host_dout;
   logic        map_we = 1'b0;
   logic        map_rd = 1'b0;
   logic [9:0]  map_idx = '0;
   logic [15:0] map_wdata = '0;
   logic [15:0] map_rdata;

   always #4 clk = ~clk;   // 125 MHz

   pgxlat_map u_pgxlat_map (
      .clk(clk), .rst_n(rst_n),
      .chip_req(chip_req), .chip_addr(chip_addr), .chip_din(chip_din),
      .chip_phys(chip_phys), .chip_swap(chip_swap), .chip_aux(chip_aux), .chip_dout(chip_dout),
      .host_req(host_req), .host_addr(host_addr), .host_din(host_din),
      .host_phys(host_phys), .host_swap(host_swap), .host_aux(host_aux), .host_dout(host_dout),
      .map_we(map_we), .map_rd(map_rd), .map_idx(map_idx),
      .map_wdata(map_wdata), .map_rdata(map_rdata)
   );

   typedef struct {
      int          kind;    // 0 chip, 1 host, 2 readback
      string       tag;
      logic [39:0] exp;
   } item_t;

   item_t       sb[$];
   logic [15:0] model [1024];
   int          total = 0;
   int          bad = 0;
   bit          done = 1'b0;
   logic [31:0] lf = 32'h1ACE_B00C;

   function automatic logic [39:0] expect_xl(logic req, logic [19:0] eff, logic [15:0] din);
      logic [15:0] e;
      logic [15:0] d;
      if (!req) return '0;
      e = model[eff[19:10]];
      d = e[15] ? {din[7:0], din[15:8]} : din;
      return {e[11:0], eff[9:0], e[15], e[13], d};
   endfunction

   function automatic logic [31:0] step(logic [31:0] v);
      return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
   endfunction

   // Monitor: compare each expected item in the cycle it was queued.
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         item_t it;
         logic [39:0] act;
         it = sb.pop_front();
         case (it.kind)
            0:       act = {chip_phys, chip_swap, chip_aux, chip_dout};
            1:       act = {host_phys, host_swap, host_aux, host_dout};
            default: act = {24'h0, map_rdata};
         endcase
         total++;
         if (act !== it.exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
         end
      end
   end

   task automatic drv_idle();
      @(posedge clk); #1;
      map_we = 1'b0; map_rd = 1'b0; chip_req = 1'b0; host_req = 1'b0;
   endtask

   task automatic drv_wr(logic [9:0] idx, logic [15:0] val);
      @(posedge clk); #1;
      map_we = 1'b1; map_rd = 1'b0; chip_req = 1'b0; host_req = 1'b0;
      map_idx = idx; map_wdata = val;
      model[idx] = val;
   endtask

   task automatic drv_chip(logic req, logic [23:0] a, logic [15:0] d, string tag);
      item_t it;
      @(posedge clk); #1;
      map_we = 1'b0; map_rd = 1'b0; host_req = 1'b0;
      chip_req = req; chip_addr = a; chip_din = d;
      it.kind = 0; it.tag = tag; it.exp = expect_xl(req, a[19:0], d);
      sb.push_back(it);
   endtask

   task automatic drv_host(logic [19:0] a, logic [15:0] d, string tag);
      item_t it;
      @(posedge clk); #1;
      map_we = 1'b0; map_rd = 1'b0; chip_req = 1'b0;
      host_req = 1'b1; host_addr = a; host_din = d;
      it.kind = 1; it.tag = tag; it.exp = expect_xl(1'b1, a, d);
      sb.push_back(it);
   endtask

   task automatic drv_rb(logic [9:0] idx, string tag);
      item_t it;
      @(posedge clk); #1;
      map_we = 1'b0; map_rd = 1'b1; chip_req = 1'b0; host_req = 1'b0;
      map_idx = idx;
      @(posedge clk); #1;
      map_rd = 1'b0;
      it.kind = 2; it.tag = tag; it.exp = {24'h0, model[idx]};
      sb.push_back(it);
   endtask

   // Write and translate the same slot in one cycle: old entry expected.
   task automatic drv_wr_xl(logic [9:0] idx, logic [15:0] val, logic [23:0] a, logic [15:0] d);
      item_t it;
      @(posedge clk); #1;
      map_we = 1'b1; map_rd = 1'b0; host_req = 1'b0;
      map_idx = idx; map_wdata = val;
      chip_req = 1'b1; chip_addr = a; chip_din = d;
      it.kind = 0; it.tag = "R7 same-cycle write"; it.exp = expect_xl(1'b1, a[19:0], d);
      sb.push_back(it);
      model[idx] = val;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      item_t it;
      repeat (3) @(posedge clk);
      #1;
      // Reset state: readback 0, idle chip outputs 0 (R8, R10).
      it.kind = 2; it.tag = "R8 reset readback"; it.exp = '0;
      sb.push_back(it);
      @(negedge clk);
      rst_n = 1'b1;
      drv_chip(1'b0, 24'h123456, 16'hA5C3, "R10 idle after reset");

      // Program every slot: direct map, mixed flags and stray bits 14/12.
      for (int i = 0; i < 1023; i++) begin
         logic [15:0] v;
         v = {i[0], i[2], i[1], i[3], i[11:0]};
         drv_wr(i[9:0], v);
      end
      drv_wr(10'd1023, 16'h8000);   // last slot aliases frame 0, swapped
      drv_wr(10'd0,    16'h8000);   // first page at frame 0, swapped

      // R1/R2/R3/R4/R5: random chip addresses, random top nibble.
      for (int n = 0; n < 200; n++) begin
         lf = step(lf);
         drv_chip(1'b1, lf[23:0], lf[31:16], "R1 R2 R3 R4 R5 chip xlat");
      end

      // R1: same low 20 bits, different top nibbles.
      drv_chip(1'b1, 24'h0ABCDE, 16'h1234, "R1 nibble 0");
      drv_chip(1'b1, 24'hFABCDE, 16'h1234, "R1 nibble F");
      drv_chip(1'b1, 24'h5ABCDE, 16'h1234, "R1 nibble 5");

      // R4/R5 explicit flag patterns.
      drv_wr(10'd7, 16'h2ABC);   // aux, no swap, frame 0xABC
      drv_chip(1'b1, 24'h001C55, 16'hBEEF, "R5 aux set no swap");
      drv_wr(10'd7, 16'h5123);   // bits 14 and 12 only, frame 0x123
      drv_chip(1'b1, 24'h001C55, 16'hBEEF, "R5 stray bits ignored");
      drv_wr(10'd7, 16'h8FFF);   // swap only
      drv_chip(1'b1, 24'h001C55, 16'hBEEF, "R4 swap set");

      // R6: host side through the same table.
      for (int n = 0; n < 100; n++) begin
         lf = step(lf);
         drv_host(lf[19:0], lf[31:16], "R6 host xlat");
      end
      drv_host(20'hFFFF4, 16'hCAFE, "R6 host alias slot");

      // R9: start-up pointer alias.
      drv_chip(1'b1, 24'hFFFFF4, 16'h0102, "R9 pointer slot");
      drv_chip(1'b1, 24'h0003F4, 16'h0102, "R9 slot 0 twin");

      // R7: same-cycle write sees old, next cycle sees new, held steady.
      drv_wr(10'd40, 16'h0011);
      drv_wr_xl(10'd40, 16'hA022, 24'h30A0F0, 16'h5566);
      drv_chip(1'b1, 24'h30A0F0, 16'h5566, "R7 after write");
      drv_chip(1'b1, 24'h30A0F0, 16'h5566, "R7 held");

      // R8: readback of full entries including stray bits.
      drv_rb(10'd7, "R8 readback 7");
      drv_rb(10'd40, "R8 readback 40");
      drv_rb(10'd1023, "R8 readback 1023");
      drv_rb(10'd13, "R8 readback 13");
      drv_idle();
      it.kind = 2; it.tag = "R8 hold"; it.exp = {24'h0, model[13]};
      sb.push_back(it);

      // R11: a read with map_we low must leave the entry intact.
      drv_rb(10'd100, "R11 read 100");
      drv_chip(1'b1, 24'h019004, 16'h7788, "R11 xlat after read");
      drv_rb(10'd100, "R11 reread 100");

      // R10: idle sides are quiet.
      drv_chip(1'b0, 24'hFFFFFF, 16'hFFFF, "R10 idle chip");

      drv_idle();
      drv_idle();
      if (sb.size() != 0) begin
         total++;
         bad++;
         $display("FAIL scoreboard: actual=%0d expected=0 pending", sb.size());
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule